// File: doc/BRIEF.md
# Display Power and Initialisation Sequencer

This block brings a self-emissive display panel up and takes it down again in a fixed order. It drives the logic-supply enable, the high-voltage panel-supply enable and an active-low reset for the panel controller. It sends commands to the controller through a byte-wide write request interface that feeds a separate bus writer. A single-cycle start request begins power-up, and a single-cycle stop request begins power-down.

During power-up the block waits on millisecond delays around the controller reset. It then sends display-off and walks a small constant table of register settings. Next it selects the controller's RAM access register and writes zero for red, green and blue to every pixel. Only after that does it enable the high-voltage rail, wait 100 ms and send display-on. Power-down runs the reverse order. All delays come from a prescaler that is derived from the clock-frequency parameter, so each wait lasts an exact number of cycles.

Top module: `oled_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and at release, `vdd_en`, `vhv_en`, `wr_valid`, `busy` and `panel_on` are 0, and `ctl_rst_n` is 1.
- R2: A start pulse while off raises `vdd_en` and `busy`. Exactly one millisecond (CLK_HZ/1000 cycles) later, `ctl_rst_n` drops for one millisecond. The first transfer becomes valid exactly one millisecond after `ctl_rst_n` returns high.
- R3: Each transfer is one cycle with `wr_valid` and `wr_ready` both high. `wr_cmd`=1 marks a register index and `wr_cmd`=0 marks a value. While `wr_valid` is high and `wr_ready` is low, `wr_cmd` and `wr_data` hold and `wr_valid` stays high. Transfers only occur with `vdd_en` and `ctl_rst_n` high.
- R4: The first transfers of power-up are the display-off pair (index 0x06, value 0x00). They are followed by these index/value pairs in this order: 08/03, 09/05, 0A/05, 0B/0A, 0C/0A, 0D/0A, 2D/00, 2E/00, 2F/00, 31/00, 32/00.
- R5: The clear step sends index 0x22 and then 3·PANEL_W·PANEL_H value transfers of 0x00. `vhv_en` stays 0 and `busy` stays 1 through the last of them.
- R6: `vhv_en` rises only after the last clear transfer. The display-on pair (index 0x06, value 0x01) becomes valid exactly 100 ms after `vhv_en` rises. After it completes, `panel_on`=1 and `busy`=0.
- R7: A stop pulse while on sends the display-off pair (0x06, 0x00) with `vhv_en` still 1, then drops `vhv_en`. `vdd_en` falls exactly 100 ms later, leaving `busy`=0.
- R8: A stop pulse received during power-up is held. Power-up finishes, `panel_on` goes high for at least one cycle, and then power-down runs without a further request.
- R9: A start pulse while on or during power-down, and a stop pulse while off, cause no transfer and no change of the supply enables.
- R10: `vhv_en` is never 1 while `vdd_en` is 0, and `vdd_en` never falls in the cycle after `vhv_en` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Start power-up pulse |
| off_req | input | 1 | Start power-down pulse |
| wr_ready | input | 1 | Writer accepts the current transfer |
| vdd_en | output | 1 | Logic supply enable |
| vhv_en | output | 1 | High-voltage panel supply enable |
| ctl_rst_n | output | 1 | Controller reset, active low |
| wr_valid | output | 1 | Transfer request |
| wr_cmd | output | 1 | 1 = register index, 0 = value |
| wr_data | output | 8 | Transfer byte |
| busy | output | 1 | A sequence is in progress |
| panel_on | output | 1 | Panel is fully on |

## Verification
The hardest case to reach is a stop request that arrives in the middle of the register table walk. It has to survive the whole clear step and the 100 ms settle before it has any effect. The bench starts a power-up, waits for the first transfer, and issues the stop a few cycles later. It then checks that the scoreboard receives the complete power-up stream followed by the power-down pair. The writer's ready line stalls one cycle in three throughout, so the hold rule is exercised on every kind of transfer. A small clock-frequency parameter keeps the 100 ms windows to a few hundred cycles, while they remain exact.

// File: rtl/oled_pwr_seq.sv
module oled_pwr_seq #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int RST_MS    = 1,
  parameter int SETTLE_MS = 100,
  parameter int PANEL_W   = 160,
  parameter int PANEL_H   = 128,
  parameter logic [7:0] DISP_REG = 8'h06,
  parameter logic [7:0] RAM_REG  = 8'h22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       on_req,
  input  logic       off_req,
  input  logic       wr_ready,
  output logic       vdd_en,
  output logic       vhv_en,
  output logic       ctl_rst_n,
  output logic       wr_valid,
  output logic       wr_cmd,
  output logic [7:0] wr_data,
  output logic       busy,
  output logic       panel_on
);
  localparam int CYC_MS = CLK_HZ / 1000;
  localparam int INIT_N = 11;
  localparam int NCLR   = 3 * PANEL_W * PANEL_H;
  localparam int MAXX   = (NCLR > 2 * INIT_N) ? NCLR : 2 * INIT_N;
  localparam int CW     = $clog2(MAXX + 1);
  localparam int PW     = $clog2(CYC_MS + 1);
  localparam int MAXMS  = (SETTLE_MS > RST_MS) ? SETTLE_MS : RST_MS;
  localparam int MW     = $clog2(MAXMS + 1);

  typedef enum logic [3:0] {
    S_OFF, S_VDD, S_RST, S_RWAIT, S_DOFF, S_INIT, S_SEL, S_CLR,
    S_HV, S_DON, S_ON, S_PDOFF, S_PWAIT
  } st_t;

  st_t            state, nxt;
  logic [PW-1:0]  pre;
  logic [MW-1:0]  ms, lim;
  logic [CW-1:0]  cnt, nx;
  logic           off_pend, timed, tmr_done, xfer, last_x;
  logic [15:0]    pair;

  function automatic logic [15:0] init_pair(input logic [4:0] i);
    case (i)
      5'd0:    return 16'h0803;
      5'd1:    return 16'h0905;
      5'd2:    return 16'h0A05;
      5'd3:    return 16'h0B0A;
      5'd4:    return 16'h0C0A;
      5'd5:    return 16'h0D0A;
      5'd6:    return 16'h2D00;
      5'd7:    return 16'h2E00;
      5'd8:    return 16'h2F00;
      5'd9:    return 16'h3100;
      default: return 16'h3200;
    endcase
  endfunction

  assign timed    = state inside {S_VDD, S_RST, S_RWAIT, S_HV, S_PWAIT};
  assign lim      = (state inside {S_HV, S_PWAIT}) ? MW'(SETTLE_MS) : MW'(RST_MS);
  assign tmr_done = timed && (pre == PW'(CYC_MS - 1)) && (ms == lim - MW'(1));
  assign xfer     = wr_valid && wr_ready;
  assign last_x   = cnt == nx - CW'(1);
  assign pair     = init_pair(5'(cnt >> 1));

  assign vdd_en    = state != S_OFF;
  assign vhv_en    = state inside {S_HV, S_DON, S_ON, S_PDOFF};
  assign ctl_rst_n = state != S_RST;
  assign wr_valid  = state inside {S_DOFF, S_INIT, S_SEL, S_CLR, S_DON, S_PDOFF};
  assign busy      = !(state inside {S_OFF, S_ON});
  assign panel_on  = state == S_ON;

  always_comb begin
    case (state)
      S_INIT:  nx = CW'(2 * INIT_N);
      S_SEL:   nx = CW'(1);
      S_CLR:   nx = CW'(NCLR);
      default: nx = CW'(2);
    endcase
  end

  always_comb begin
    wr_cmd  = !cnt[0];
    wr_data = 8'h00;
    case (state)
      S_DOFF, S_PDOFF: wr_data = cnt[0] ? 8'h00 : DISP_REG;
      S_DON:           wr_data = cnt[0] ? 8'h01 : DISP_REG;
      S_INIT:          wr_data = cnt[0] ? pair[7:0] : pair[15:8];
      S_SEL:           begin wr_cmd = 1'b1; wr_data = RAM_REG; end
      S_CLR:           wr_cmd = 1'b0;
      default:         wr_data = 8'h00;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      S_OFF:   if (on_req) nxt = S_VDD;
      S_VDD:   if (tmr_done) nxt = S_RST;
      S_RST:   if (tmr_done) nxt = S_RWAIT;
      S_RWAIT: if (tmr_done) nxt = S_DOFF;
      S_DOFF:  if (xfer && last_x) nxt = S_INIT;
      S_INIT:  if (xfer && last_x) nxt = S_SEL;
      S_SEL:   if (xfer && last_x) nxt = S_CLR;
      S_CLR:   if (xfer && last_x) nxt = S_HV;
      S_HV:    if (tmr_done) nxt = S_DON;
      S_DON:   if (xfer && last_x) nxt = S_ON;
      S_ON:    if (off_req || off_pend) nxt = S_PDOFF;
      S_PDOFF: if (xfer && last_x) nxt = S_PWAIT;
      S_PWAIT: if (tmr_done) nxt = S_OFF;
      default: nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      pre      <= '0;
      ms       <= '0;
      cnt      <= '0;
      off_pend <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_ON)
        off_pend <= 1'b0;
      else if (off_req && (state inside {S_VDD, S_RST, S_RWAIT, S_DOFF, S_INIT, S_SEL, S_CLR, S_HV, S_DON}))
        off_pend <= 1'b1;
      if (nxt != state) begin
        pre <= '0;
        ms  <= '0;
        cnt <= '0;
      end else begin
        if (timed) begin
          if (pre == PW'(CYC_MS - 1)) begin
            pre <= '0;
            ms  <= ms + MW'(1);
          end else begin
            pre <= pre + PW'(1);
          end
        end
        if (xfer) cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/oled_pwr_seq_chk.sv
module oled_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vdd_en,
  input logic       vhv_en,
  input logic       ctl_rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       wr_cmd,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic       panel_on
);
  // R10
  hv_needs_vdd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vhv_en |-> vdd_en);
  // R10
  vdd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_en) |-> !$past(vhv_en));
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_cmd)));
  // R3
  xfer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (vdd_en && ctl_rst_n));
  // R6
  on_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    panel_on |-> (vhv_en && !busy));
  // R5
  hv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vhv_en) |-> (busy && !wr_valid));
  // R2
  rst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rst_n |-> (vdd_en && busy && !vhv_en));
endmodule

bind oled_pwr_seq oled_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vdd_en(vdd_en), .vhv_en(vhv_en),
  .ctl_rst_n(ctl_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_cmd(wr_cmd), .wr_data(wr_data), .busy(busy), .panel_on(panel_on)
);

// File: tb/test_oled_pwr_seq.sv
module test_oled_pwr_seq;
  localparam int HZ = 4000;
  localparam int C  = HZ / 1000;
  localparam int W  = 4;
  localparam int H  = 3;
  localparam logic [15:0] ROM [11] = '{16'h0803, 16'h0905, 16'h0A05, 16'h0B0A,
    16'h0C0A, 16'h0D0A, 16'h2D00, 16'h2E00, 16'h2F00, 16'h3100, 16'h3200};

  logic clk = 0, rst_n = 0, on_req = 0, off_req = 0, wr_ready = 1;
  logic vdd_en, vhv_en, ctl_rst_n, wr_valid, wr_cmd, busy, panel_on;
  logic [7:0] wr_data;

  oled_pwr_seq #(.CLK_HZ(HZ), .PANEL_W(W), .PANEL_H(H)) i_oled_pwr_seq (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .wr_ready(wr_ready), .vdd_en(vdd_en), .vhv_en(vhv_en),
    .ctl_rst_n(ctl_rst_n), .wr_valid(wr_valid), .wr_cmd(wr_cmd),
    .wr_data(wr_data), .busy(busy), .panel_on(panel_on));

  always #10 clk = ~clk;

  int vec = 0, miss = 0, n = 0, rc = 0;
  bit done = 0, saw_on = 0, want_first = 0, want_don = 0;
  int t_vdd_up, t_rst_dn, t_rst_up, t_first, t_hv_up, t_don, t_hv_dn, t_vdd_dn;
  logic p_vdd = 0, p_rst = 1, p_hv = 0, p_valid = 0, p_ready = 0, p_cmd = 0;
  logic [7:0] p_data = 0;
  logic [9:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic hv, input logic cmd, input logic [7:0] d);
    exp_q.push_back({hv, cmd, d});
  endtask

  task automatic push_up();
    push(0, 1, 8'h06); push(0, 0, 8'h00);
    for (int i = 0; i < 11; i++) begin
      push(0, 1, ROM[i][15:8]); push(0, 0, ROM[i][7:0]);
    end
    push(0, 1, 8'h22);
    for (int i = 0; i < 3 * W * H; i++) push(0, 0, 8'h00);
    push(1, 1, 8'h06); push(1, 0, 8'h01);
  endtask

  task automatic push_down();
    push(1, 1, 8'h06); push(1, 0, 8'h00);
  endtask

  task automatic pulse_on();
    @(posedge clk); #1 on_req = 1;
    @(posedge clk); #1 on_req = 0;
  endtask

  task automatic pulse_off();
    @(posedge clk); #1 off_req = 1;
    @(posedge clk); #1 off_req = 0;
  endtask

  // writer ready: stalls one cycle in three
  initial forever begin
    @(posedge clk); #1 wr_ready = (rc % 3) != 2; rc++;
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    n++;
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0)
          chk(0, "R9 unexpected transfer", {vhv_en, wr_cmd, wr_data}, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({vhv_en, wr_cmd, wr_data} == e, "R4 R5 R6 R7 transfer {hv,cmd,data}",
              {vhv_en, wr_cmd, wr_data}, e);
          chk(busy == 1, "R5 busy during transfer", busy, 1);
        end
      end
      if (p_valid && !p_ready)
        chk(wr_valid && wr_cmd == p_cmd && wr_data == p_data, "R3 hold under stall",
            {wr_valid, wr_cmd, wr_data}, {1'b1, p_cmd, p_data});
      if (panel_on) saw_on = 1;
      if (vdd_en && !p_vdd) t_vdd_up = n;
      if (!vdd_en && p_vdd) t_vdd_dn = n;
      if (!ctl_rst_n && p_rst) t_rst_dn = n;
      if (ctl_rst_n && !p_rst) begin t_rst_up = n; want_first = 1; end
      if (vhv_en && !p_hv) begin t_hv_up = n; want_don = 1; end
      if (!vhv_en && p_hv) t_hv_dn = n;
      if (wr_valid && !p_valid) begin
        if (want_first) begin t_first = n; want_first = 0; end
        if (want_don) begin t_don = n; want_don = 0; end
      end
    end
    p_vdd = vdd_en; p_rst = ctl_rst_n; p_hv = vhv_en; p_valid = wr_valid;
    p_ready = wr_ready; p_cmd = wr_cmd; p_data = wr_data;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vec++; miss++;
      $display("FAIL R1-watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({vdd_en, vhv_en, wr_valid, busy, panel_on, ctl_rst_n} == 6'b000001,
        "R1 reset outputs", {vdd_en, vhv_en, wr_valid, busy, panel_on, ctl_rst_n}, 6'b000001);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk({vdd_en, busy} == 2'b00, "R1 after release", {vdd_en, busy}, 0);

    // full power-up
    push_up();
    pulse_on();
    while (!panel_on) @(negedge clk);
    chk(t_rst_dn - t_vdd_up == C, "R2 vdd to reset", t_rst_dn - t_vdd_up, C);
    chk(t_rst_up - t_rst_dn == C, "R2 reset width", t_rst_up - t_rst_dn, C);
    chk(t_first - t_rst_up == C, "R2 reset to first transfer", t_first - t_rst_up, C);
    chk(t_don - t_hv_up == 100 * C, "R6 hv to display-on", t_don - t_hv_up, 100 * C);
    chk(busy == 0 && vhv_en == 1, "R6 on status", {busy, vhv_en}, 2'b01);
    chk(exp_q.size() == 0, "R4 stream complete", exp_q.size(), 0);

    // start request while on: ignored
    pulse_on();
    repeat (30) @(negedge clk);
    chk(panel_on && vdd_en && vhv_en, "R9 start while on", {panel_on, vdd_en, vhv_en}, 3'b111);

    // power-down, with a start pulse during the settle wait
    push_down();
    pulse_off();
    while (vhv_en) @(negedge clk);
    pulse_on();
    while (vdd_en) @(negedge clk);
    chk(t_vdd_dn - t_hv_dn == 100 * C, "R7 hv off to vdd off", t_vdd_dn - t_hv_dn, 100 * C);
    chk(!busy && !panel_on, "R7 off status", {busy, panel_on}, 0);
    chk(exp_q.size() == 0, "R7 display-off sent", exp_q.size(), 0);
    repeat (30) @(negedge clk);
    chk(!vdd_en && !busy, "R9 start during power-down", {vdd_en, busy}, 0);

    // stop request while off: ignored
    pulse_off();
    repeat (30) @(negedge clk);
    chk(!vdd_en && !vhv_en && !busy, "R9 stop while off", {vdd_en, vhv_en, busy}, 0);

    // stop during power-up is held until on
    push_up();
    push_down();
    saw_on = 0;
    pulse_on();
    while (!wr_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    pulse_off();
    while (vdd_en || busy) @(negedge clk);
    chk(saw_on == 1, "R8 on reached before power-down", saw_on, 1);
    chk(exp_q.size() == 0, "R8 full stream then off pair", exp_q.size(), 0);
    chk(t_vdd_dn - t_hv_dn == 100 * C, "R7 R8 settle after held stop", t_vdd_dn - t_hv_dn, 100 * C);
    chk(t_first - t_rst_up == C, "R2 second power-up", t_first - t_rst_up, C);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule